// File: doc/BRIEF.md
# Prefixed Vector Instruction Format Decoder

This block is a purely combinational decoder for a 48-bit prefixed vector instruction. The upper 32 bits, 47:16, carry an ordinary base instruction. The low 18 bits carry the prefix. The decoder looks at the base major opcode, and for floating-point arithmetic also at its top five function bits. From these it picks one of eight prefix layouts. It then pulls the per-operand scalar or vector flags and the sixth register-number bits out of the prefix.

For every operand it builds a 7-bit register number. A scalar operand gets a zero-extended number. A vector operand gets a rotated number: the low bit of the 6-bit field moves to the top and bit 0 is forced to zero. A flag that a layout leaves out is taken as the OR of the flags it does carry. The packed type/predicate/sub-vector-length field is unpacked into element type, predicate (or twin-predicate) code and sub-vector length. Any reserved selection raises `illegal`.

The decoder sits in an instruction decode stage. Its outputs feed register renaming and the vector loop sequencer. While `illegal` is high, the other outputs carry no meaning.

Top module: `prefix_decoder`

## Requirements
- R1: `illegal` is 1 whenever bits 5:0 differ from 011111 or bit 6 is 1.
- R2: Format codes on `fmt` are 1 LD, 2 ST, 3 R, 4 I, 5 U, 6 FR, 7 FI and 8 FR4. Base opcode bits 6:2 (instruction bits 22:18) of 00000 or 00001 (integer or FP load) give LD. Values 01000 or 01001 (integer or FP store) give ST.
- R3: The integer opcodes map as follows:
  - 01100 and 01110 give R.
  - 00100, 00110 and 11001 give I.
  - 01101 and 00101 give U.
  - Branch (11000), jump (11011), system (11100) and every opcode not named in R2 to R4 set `illegal`.
- R4: Opcode 10100 (FP arithmetic) gives FI when instruction bits 47:43 are 01011, 01000, 11000, 11010, 11100 or 11110, and FR otherwise. Opcodes 10000 to 10011 (fused multiply-add) give FR4.
- R5: A scalar operand's number is {0, ext, base[4:0]}. The sixth bit `ext` is insn[17] for rd (insn[16] for ST's rs1 is not rd), insn[16] for rs1, insn[15] for rs2 and insn[13] for rs3 (FR4 only). Base fields are rd 27:23, rs1 35:31, rs2 40:36 and rs3 47:43.
- R6: A vector operand's number is {field[0], field[5:1], 0}, where field = {ext, base[4:0]}.
- R7: Flag bits are insn[14] (vd in LD/I/FI/U, vs2 in ST/R/FR/FR4), insn[13] (vs1 in LD/ST/R/I/FR/FI) and insn[12] (vs3 in FR4). Any operand a format uses but gives no flag takes the OR of the flags that are present: rd in R, FR and FR4, and rs1 in FR4.
- R8: LD, I and FI use a 7-bit field {insn[15], insn[12:7]}; ST uses {insn[17], insn[12:7]}. From field v: `itype` = v[5:4], `pred` = {v[6], v[3:2]}, `pred_twin` = 1, svlen code = v[1:0].
- R9: R and U use v = insn[12:7]. v[3:2] = 01 sets `illegal`. Otherwise `itype` = v[5:4], `pred` = {0, v[3:2]}, `pred_twin` = 0, svlen code = v[1:0].
- R10: FR and FR4 use v = insn[11:7]. v[4:2] = 001 sets `illegal`. Otherwise `pred` = v[4:2], `itype` = 0, `pred_twin` = 0, svlen code = v[1:0].
- R11: `svlen` is 4 for code 00, and equals the code for 01, 10 and 11.
- R12: `illegal` is 1 when a U-format prefix has any of bits 16, 15 or 13 set, or an FR-format prefix has bit 12 set.
- R13: An operand absent from the selected format drives number 0 and vector flag 0. This covers rs2 in LD/I/FI/U, rs1 in U, rd in ST, and rs3 outside FR4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn | input | 48 | Prefixed instruction word |
| fmt | output | 4 | Selected prefix format code |
| illegal | output | 1 | Reserved encoding or non-zero reserved bit |
| rd_num | output | 7 | Destination register number |
| rs1_num | output | 7 | First source register number |
| rs2_num | output | 7 | Second source register number |
| rs3_num | output | 7 | Third source register number |
| rd_vec | output | 1 | Destination is a vector |
| rs1_vec | output | 1 | First source is a vector |
| rs2_vec | output | 1 | Second source is a vector |
| rs3_vec | output | 1 | Third source is a vector |
| itype | output | 2 | Integer element type code |
| pred | output | 3 | Predicate or twin-predicate code |
| pred_twin | output | 1 | `pred` holds a twin-predicate code |
| svlen | output | 3 | Sub-vector length, 1 to 4 |

## Verification
The decoder holds no state, so any fault appears on the ports in the same evaluation as the instruction that exposes it. A wrong layout choice shows up as a shifted field: an extension bit taken from a neighbouring prefix position, or a flag taken from the wrong operand. Such faults surface only for operands whose sixth bit or flag is set. For that reason, the directed vectors set those bits asymmetrically, and a full sweep of the 6-bit register field is run in both scalar and vector mode. The inferred-flag combinations and every svlen code are walked exhaustively, because a mistake there changes only one output bit.

// File: rtl/pfxdec_pkg.sv
package pfxdec_pkg;

    localparam int NOPS   = 4;   // rd, rs1, rs2, rs3
    localparam int BASE_W = 5;
    localparam int FLD_W  = BASE_W + 1;
    localparam int REG_W  = FLD_W + 1;
    localparam int LOW_W  = 18;
    localparam int INSN_W = 48;
    localparam int TF_W   = 7;

    localparam int OP_RD  = 0;
    localparam int OP_RS1 = 1;
    localparam int OP_RS2 = 2;
    localparam int OP_RS3 = 3;

    localparam logic [5:0] PFX_MAJOR = 6'b011111;

    // base major opcode, bits 6:2
    localparam logic [4:0] OPC_LOAD     = 5'b00000;
    localparam logic [4:0] OPC_LOAD_FP  = 5'b00001;
    localparam logic [4:0] OPC_STORE    = 5'b01000;
    localparam logic [4:0] OPC_STORE_FP = 5'b01001;
    localparam logic [4:0] OPC_OPIMM    = 5'b00100;
    localparam logic [4:0] OPC_OPIMM32  = 5'b00110;
    localparam logic [4:0] OPC_OP       = 5'b01100;
    localparam logic [4:0] OPC_OP32     = 5'b01110;
    localparam logic [4:0] OPC_LUI      = 5'b01101;
    localparam logic [4:0] OPC_AUIPC    = 5'b00101;
    localparam logic [4:0] OPC_JALR     = 5'b11001;
    localparam logic [4:0] OPC_OPFP     = 5'b10100;
    localparam logic [4:0] OPC_MADD     = 5'b10000;
    localparam logic [4:0] OPC_MSUB     = 5'b10001;
    localparam logic [4:0] OPC_NMSUB    = 5'b10010;
    localparam logic [4:0] OPC_NMADD    = 5'b10011;

    typedef enum logic [3:0] {
        FMT_NONE = 4'd0,
        FMT_LD   = 4'd1,
        FMT_ST   = 4'd2,
        FMT_R    = 4'd3,
        FMT_I    = 4'd4,
        FMT_U    = 4'd5,
        FMT_FR   = 4'd6,
        FMT_FI   = 4'd7,
        FMT_FR4  = 4'd8
    } pfx_fmt_e;

    typedef enum logic [1:0] {
        TK_NONE = 2'd0,
        TK_W7   = 2'd1,
        TK_W6   = 2'd2,
        TK_W5   = 2'd3
    } tfield_kind_e;

    typedef struct packed {
        logic [1:0] itype;
        logic [2:0] pred;
        logic       twin;
        logic [2:0] svlen;
        logic       bad;
    } tinfo_s;

    typedef struct packed {
        logic [NOPS-1:0] present;
        logic [NOPS-1:0] ext;
        logic [NOPS-1:0] fvalid;
        logic [NOPS-1:0] fval;
        logic            rsvd_bad;
        tfield_kind_e    tkind;
        logic [TF_W-1:0] traw;
    } layout_s;

    function automatic logic [REG_W-1:0] num_scalar(input logic [FLD_W-1:0] f);
        return {1'b0, f};
    endfunction

    function automatic logic [REG_W-1:0] num_vector(input logic [FLD_W-1:0] f);
        return {f[0], f[FLD_W-1:1], 1'b0};
    endfunction

    function automatic logic [2:0] svlen_of(input logic [1:0] code);
        return (code == 2'b00) ? 3'd4 : {1'b0, code};
    endfunction

    function automatic logic is_fp_unary(input logic [4:0] f5);
        return (f5 == 5'b01011) || (f5 == 5'b01000) || (f5 == 5'b11000) ||
               (f5 == 5'b11010) || (f5 == 5'b11100) || (f5 == 5'b11110);
    endfunction

endpackage

// File: rtl/pfxdec_fmt_sel.sv
module pfxdec_fmt_sel
    import pfxdec_pkg::*;
(
    input  logic [4:0] opc_i,
    input  logic [4:0] funct5_i,
    output pfx_fmt_e   fmt_o
);
    always_comb begin
        fmt_o = FMT_NONE;
        unique case (opc_i)
            OPC_LOAD, OPC_LOAD_FP:            fmt_o = FMT_LD;
            OPC_STORE, OPC_STORE_FP:          fmt_o = FMT_ST;
            OPC_OP, OPC_OP32:                 fmt_o = FMT_R;
            OPC_OPIMM, OPC_OPIMM32, OPC_JALR: fmt_o = FMT_I;
            OPC_LUI, OPC_AUIPC:               fmt_o = FMT_U;
            OPC_OPFP:                         fmt_o = is_fp_unary(funct5_i) ? FMT_FI : FMT_FR;
            OPC_MADD, OPC_MSUB,
            OPC_NMSUB, OPC_NMADD:             fmt_o = FMT_FR4;
            default:                          fmt_o = FMT_NONE;
        endcase
    end
endmodule

// File: rtl/pfxdec_layout.sv
module pfxdec_layout
    import pfxdec_pkg::*;
(
    input  pfx_fmt_e         fmt_i,
    input  logic [LOW_W-1:0] low_i,
    output layout_s          lay_o
);
    always_comb begin
        lay_o          = '0;
        lay_o.tkind    = TK_NONE;
        unique case (fmt_i)
            FMT_LD, FMT_I, FMT_FI: begin
                lay_o.present[OP_RD]  = 1'b1;
                lay_o.present[OP_RS1] = 1'b1;
                lay_o.ext[OP_RD]      = low_i[17];
                lay_o.ext[OP_RS1]     = low_i[16];
                lay_o.fvalid[OP_RD]   = 1'b1;
                lay_o.fval[OP_RD]     = low_i[14];
                lay_o.fvalid[OP_RS1]  = 1'b1;
                lay_o.fval[OP_RS1]    = low_i[13];
                lay_o.tkind           = TK_W7;
                lay_o.traw            = {low_i[15], low_i[12:7]};
            end
            FMT_ST: begin
                lay_o.present[OP_RS1] = 1'b1;
                lay_o.present[OP_RS2] = 1'b1;
                lay_o.ext[OP_RS1]     = low_i[16];
                lay_o.ext[OP_RS2]     = low_i[15];
                lay_o.fvalid[OP_RS2]  = 1'b1;
                lay_o.fval[OP_RS2]    = low_i[14];
                lay_o.fvalid[OP_RS1]  = 1'b1;
                lay_o.fval[OP_RS1]    = low_i[13];
                lay_o.tkind           = TK_W7;
                lay_o.traw            = {low_i[17], low_i[12:7]};
            end
            FMT_R, FMT_FR: begin
                lay_o.present[OP_RD]  = 1'b1;
                lay_o.present[OP_RS1] = 1'b1;
                lay_o.present[OP_RS2] = 1'b1;
                lay_o.ext[OP_RD]      = low_i[17];
                lay_o.ext[OP_RS1]     = low_i[16];
                lay_o.ext[OP_RS2]     = low_i[15];
                lay_o.fvalid[OP_RS2]  = 1'b1;
                lay_o.fval[OP_RS2]    = low_i[14];
                lay_o.fvalid[OP_RS1]  = 1'b1;
                lay_o.fval[OP_RS1]    = low_i[13];
                if (fmt_i == FMT_R) begin
                    lay_o.tkind = TK_W6;
                    lay_o.traw  = {1'b0, low_i[12:7]};
                end else begin
                    lay_o.tkind    = TK_W5;
                    lay_o.traw     = {2'b00, low_i[11:7]};
                    lay_o.rsvd_bad = low_i[12];
                end
            end
            FMT_U: begin
                lay_o.present[OP_RD] = 1'b1;
                lay_o.ext[OP_RD]     = low_i[17];
                lay_o.fvalid[OP_RD]  = 1'b1;
                lay_o.fval[OP_RD]    = low_i[14];
                lay_o.tkind          = TK_W6;
                lay_o.traw           = {1'b0, low_i[12:7]};
                lay_o.rsvd_bad       = low_i[16] | low_i[15] | low_i[13];
            end
            FMT_FR4: begin
                lay_o.present        = '1;
                lay_o.ext[OP_RD]     = low_i[17];
                lay_o.ext[OP_RS1]    = low_i[16];
                lay_o.ext[OP_RS2]    = low_i[15];
                lay_o.ext[OP_RS3]    = low_i[13];
                lay_o.fvalid[OP_RS2] = 1'b1;
                lay_o.fval[OP_RS2]   = low_i[14];
                lay_o.fvalid[OP_RS3] = 1'b1;
                lay_o.fval[OP_RS3]   = low_i[12];
                lay_o.tkind          = TK_W5;
                lay_o.traw           = {2'b00, low_i[11:7]};
            end
            default: begin
                lay_o = '0;
            end
        endcase
    end
endmodule

// File: rtl/pfxdec_tunpack.sv
module pfxdec_tunpack
    import pfxdec_pkg::*;
(
    input  tfield_kind_e     kind_i,
    input  logic [TF_W-1:0]  raw_i,
    output tinfo_s           info_o
);
    always_comb begin
        info_o       = '0;
        info_o.svlen = svlen_of(raw_i[1:0]);
        unique case (kind_i)
            TK_W7: begin
                info_o.itype = raw_i[5:4];
                info_o.pred  = {raw_i[6], raw_i[3:2]};
                info_o.twin  = 1'b1;
            end
            TK_W6: begin
                info_o.itype = raw_i[5:4];
                info_o.pred  = {1'b0, raw_i[3:2]};
                info_o.bad   = (raw_i[3:2] == 2'b01);
            end
            TK_W5: begin
                info_o.pred  = raw_i[4:2];
                info_o.bad   = (raw_i[4:2] == 3'b001);
            end
            default: begin
                info_o.bad   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pfxdec_regnum.sv
module pfxdec_regnum
    import pfxdec_pkg::*;
(
    input  logic              present_i,
    input  logic              vec_i,
    input  logic              ext_i,
    input  logic [BASE_W-1:0] base_i,
    output logic [REG_W-1:0]  num_o
);
    logic [FLD_W-1:0] field;

    assign field = {ext_i, base_i};

    always_comb begin
        if (!present_i)  num_o = '0;
        else if (vec_i)  num_o = num_vector(field);
        else             num_o = num_scalar(field);
    end
endmodule

// File: rtl/prefix_decoder.sv
module prefix_decoder
    import pfxdec_pkg::*;
(
    input  logic [47:0] insn,
    output logic [3:0]  fmt,
    output logic        illegal,
    output logic [6:0]  rd_num,
    output logic [6:0]  rs1_num,
    output logic [6:0]  rs2_num,
    output logic [6:0]  rs3_num,
    output logic        rd_vec,
    output logic        rs1_vec,
    output logic        rs2_vec,
    output logic        rs3_vec,
    output logic [1:0]  itype,
    output logic [2:0]  pred,
    output logic        pred_twin,
    output logic [2:0]  svlen
);
    pfx_fmt_e                         fmt_sel;
    layout_s                          lay;
    tinfo_s                           tinfo;
    logic [NOPS-1:0][BASE_W-1:0]      op_base;
    logic [NOPS-1:0]                  op_vec;
    logic [NOPS-1:0][REG_W-1:0]       op_num;
    logic                             any_flag;
    logic                             hdr_bad;

    pfxdec_fmt_sel u_fmt (
        .opc_i    (insn[22:18]),
        .funct5_i (insn[47:43]),
        .fmt_o    (fmt_sel)
    );

    pfxdec_layout u_lay (
        .fmt_i (fmt_sel),
        .low_i (insn[LOW_W-1:0]),
        .lay_o (lay)
    );

    pfxdec_tunpack u_tun (
        .kind_i (lay.tkind),
        .raw_i  (lay.traw),
        .info_o (tinfo)
    );

    assign op_base[OP_RD]  = insn[27:23];
    assign op_base[OP_RS1] = insn[35:31];
    assign op_base[OP_RS2] = insn[40:36];
    assign op_base[OP_RS3] = insn[47:43];

    // flags missing from a layout follow the OR of those it carries
    assign any_flag = |(lay.fvalid & lay.fval);

    generate
        for (genvar k = 0; k < NOPS; k++) begin : g_op
            assign op_vec[k] = lay.present[k] &
                               (lay.fvalid[k] ? lay.fval[k] : any_flag);
            pfxdec_regnum u_rn (
                .present_i (lay.present[k]),
                .vec_i     (op_vec[k]),
                .ext_i     (lay.ext[k]),
                .base_i    (op_base[k]),
                .num_o     (op_num[k])
            );
        end
    endgenerate

    assign hdr_bad = (insn[5:0] != PFX_MAJOR) | insn[6];

    assign fmt       = fmt_sel;
    assign illegal   = hdr_bad | (fmt_sel == FMT_NONE) | lay.rsvd_bad | tinfo.bad;
    assign rd_num    = op_num[OP_RD];
    assign rs1_num   = op_num[OP_RS1];
    assign rs2_num   = op_num[OP_RS2];
    assign rs3_num   = op_num[OP_RS3];
    assign rd_vec    = op_vec[OP_RD];
    assign rs1_vec   = op_vec[OP_RS1];
    assign rs2_vec   = op_vec[OP_RS2];
    assign rs3_vec   = op_vec[OP_RS3];
    assign itype     = tinfo.itype;
    assign pred      = tinfo.pred;
    assign pred_twin = tinfo.twin;
    assign svlen     = tinfo.svlen;
endmodule

// File: rtl/prefix_decoder_chk.sv
module prefix_decoder_chk
    import pfxdec_pkg::*;
(
    input logic [47:0] insn,
    input logic [3:0]  fmt,
    input logic        illegal,
    input logic [6:0]  rd_num,
    input logic [6:0]  rs2_num,
    input logic        rd_vec,
    input logic        rs1_vec,
    input logic        rs2_vec,
    input logic [2:0]  svlen
);
    always_comb begin
        a_r1_bad_header: assert (!((insn[5:0] != 6'b011111) || insn[6]) || illegal)
            else $error("R1: bad prefix header not flagged");
        a_r6_vec_even: assert (!rd_vec || (rd_num[0] == 1'b0))
            else $error("R6: vector rd number is odd");
        a_r5_scalar_top: assert (rd_vec || (rd_num[6] == 1'b0))
            else $error("R5: scalar rd number has top bit set");
        a_r7_rd_inferred: assert (illegal || (fmt != 4'(FMT_R)) || (rd_vec == (rs1_vec | rs2_vec)))
            else $error("R7: R-format rd flag not inferred");
        a_r11_svlen_range: assert (illegal || ((svlen >= 3'd1) && (svlen <= 3'd4)))
            else $error("R11: svlen out of range");
        a_r13_absent_rs2: assert (!((fmt == 4'(FMT_LD)) || (fmt == 4'(FMT_U))) ||
                                  ((rs2_num == 7'd0) && !rs2_vec))
            else $error("R13: absent rs2 not zero");
    end
endmodule

bind prefix_decoder prefix_decoder_chk u_chk (
    .insn    (insn),
    .fmt     (fmt),
    .illegal (illegal),
    .rd_num  (rd_num),
    .rs2_num (rs2_num),
    .rd_vec  (rd_vec),
    .rs1_vec (rs1_vec),
    .rs2_vec (rs2_vec),
    .svlen   (svlen)
);

// File: tb/prefix_decoder_tb_top.sv
module prefix_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [47:0] insn = '0;
    logic [3:0]  fmt;
    logic        illegal;
    logic [6:0]  rd_num, rs1_num, rs2_num, rs3_num;
    logic        rd_vec, rs1_vec, rs2_vec, rs3_vec;
    logic [1:0]  itype;
    logic [2:0]  pred;
    logic        pred_twin;
    logic [2:0]  svlen;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    prefix_decoder dut_i (
        .insn(insn), .fmt(fmt), .illegal(illegal),
        .rd_num(rd_num), .rs1_num(rs1_num), .rs2_num(rs2_num), .rs3_num(rs3_num),
        .rd_vec(rd_vec), .rs1_vec(rs1_vec), .rs2_vec(rs2_vec), .rs3_vec(rs3_vec),
        .itype(itype), .pred(pred), .pred_twin(pred_twin), .svlen(svlen)
    );

    function automatic logic [47:0] mk(input logic [4:0] opc, input logic [4:0] f5,
                                       input logic [4:0] rd, input logic [4:0] rs1,
                                       input logic [4:0] rs2, input logic [17:0] lo);
        return {f5, 2'b00, rs2, rs1, 3'b000, rd, opc, lo};
    endfunction

    function automatic logic [17:0] lw(input logic [4:0] hi, input logic [5:0] m,
                                       input logic b6, input logic [5:0] pfx);
        return {hi, m, b6, pfx};
    endfunction

    typedef struct packed {
        logic [47:0] insn;
        logic [3:0]  fmt;
        logic        ill;
        logic [6:0]  rd, rs1, rs2, rs3;
        logic [3:0]  vec;   // {rd, rs1, rs2, rs3}
        logic [1:0]  ity;
        logic [2:0]  prd;
        logic        twin;
        logic [2:0]  svl;
        logic [3:0]  req;
    } tv_t;

    localparam int NT = 19;
    localparam tv_t TV [NT] = '{
        // R2 R6 R8 load, vector rd
        '{mk(5'b00000,5'd0,5'd3,5'd10,5'd0, lw(5'b10110,6'b101110,1'b0,6'h1f)), 4'd1,1'b0, 7'h62,7'h0A,7'h00,7'h00, 4'b1000, 2'd2,3'd7,1'b1,3'd2, 4'd2},
        // R2 R8 R13 store, vector bases
        '{mk(5'b01000,5'd0,5'd9,5'd7,5'd20, lw(5'b01011,6'b010100,1'b0,6'h1f)), 4'd2,1'b0, 7'h00,7'h66,7'h14,7'h00, 4'b0110, 2'd1,3'd1,1'b1,3'd4, 4'd2},
        // R3 R7 R9 register op, rd inferred vector
        '{mk(5'b01100,5'd0,5'd1,5'd2,5'd31, lw(5'b00101,6'b111011,1'b0,6'h1f)), 4'd3,1'b0, 7'h40,7'h02,7'h3F,7'h00, 4'b1100, 2'd3,3'd2,1'b0,3'd3, 4'd3},
        // R3 R5 R9 all scalar
        '{mk(5'b01100,5'd0,5'd5,5'd6,5'd7, lw(5'b00000,6'b000001,1'b0,6'h1f)), 4'd3,1'b0, 7'h05,7'h06,7'h07,7'h00, 4'b0000, 2'd0,3'd0,1'b0,3'd1, 4'd3},
        // R3 R8 immediate op
        '{mk(5'b00100,5'd0,5'd4,5'd8,5'd0, lw(5'b01001,6'b001011,1'b0,6'h1f)), 4'd4,1'b0, 7'h04,7'h28,7'h00,7'h00, 4'b0100, 2'd0,3'd2,1'b1,3'd3, 4'd3},
        // R3 R13 upper immediate
        '{mk(5'b01101,5'd0,5'd17,5'd0,5'd0, lw(5'b10010,6'b101100,1'b0,6'h1f)), 4'd5,1'b0, 7'h70,7'h00,7'h00,7'h00, 4'b1000, 2'd2,3'd3,1'b0,3'd4, 4'd3},
        // R4 R10 fp register op
        '{mk(5'b10100,5'd0,5'd9,5'd10,5'd11, lw(5'b00010,6'b010110,1'b0,6'h1f)), 4'd6,1'b0, 7'h48,7'h0A,7'h4A,7'h00, 4'b1010, 2'd0,3'd5,1'b0,3'd2, 4'd4},
        // R4 R8 fp unary
        '{mk(5'b10100,5'b01011,5'd2,5'd3,5'd0, lw(5'b00100,6'b010001,1'b0,6'h1f)), 4'd7,1'b0, 7'h02,7'h03,7'h00,7'h00, 4'b0000, 2'd1,3'd4,1'b1,3'd1, 4'd4},
        // R4 R7 fused multiply-add, rd and rs1 inferred
        '{mk(5'b10000,5'd12,5'd1,5'd2,5'd3, lw(5'b00101,6'b101100,1'b0,6'h1f)), 4'd8,1'b0, 7'h40,7'h02,7'h23,7'h2C, 4'b1101, 2'd0,3'd3,1'b0,3'd4, 4'd4},
        // R2 R11 fp load, all zero fields
        '{mk(5'b00001,5'd0,5'd0,5'd0,5'd0, lw(5'b00000,6'b000000,1'b0,6'h1f)), 4'd1,1'b0, 7'h00,7'h00,7'h00,7'h00, 4'b0000, 2'd0,3'd0,1'b1,3'd4, 4'd2},
        // R3 branch reserved
        '{mk(5'b11000,5'd0,5'd0,5'd0,5'd0, lw(5'b0,6'b0,1'b0,6'h1f)), 4'd0,1'b1, 7'h0,7'h0,7'h0,7'h0, 4'b0, 2'd0,3'd0,1'b0,3'd0, 4'd3},
        // R3 system reserved
        '{mk(5'b11100,5'd0,5'd0,5'd0,5'd0, lw(5'b0,6'b0,1'b0,6'h1f)), 4'd0,1'b1, 7'h0,7'h0,7'h0,7'h0, 4'b0, 2'd0,3'd0,1'b0,3'd0, 4'd3},
        // R3 jump reserved
        '{mk(5'b11011,5'd0,5'd0,5'd0,5'd0, lw(5'b0,6'b0,1'b0,6'h1f)), 4'd0,1'b1, 7'h0,7'h0,7'h0,7'h0, 4'b0, 2'd0,3'd0,1'b0,3'd0, 4'd3},
        // R9 reserved type pattern
        '{mk(5'b01100,5'd0,5'd0,5'd0,5'd0, lw(5'b0,6'b000100,1'b0,6'h1f)), 4'd0,1'b1, 7'h0,7'h0,7'h0,7'h0, 4'b0, 2'd0,3'd0,1'b0,3'd0, 4'd9},
        // R10 reserved pattern 001XX
        '{mk(5'b10100,5'd0,5'd0,5'd0,5'd0, lw(5'b0,6'b000100,1'b0,6'h1f)), 4'd0,1'b1, 7'h0,7'h0,7'h0,7'h0, 4'b0, 2'd0,3'd0,1'b0,3'd0, 4'd10},
        // R12 fp register op bit 12 set
        '{mk(5'b10100,5'd0,5'd0,5'd0,5'd0, lw(5'b0,6'b100000,1'b0,6'h1f)), 4'd0,1'b1, 7'h0,7'h0,7'h0,7'h0, 4'b0, 2'd0,3'd0,1'b0,3'd0, 4'd12},
        // R12 upper immediate bit 16 set
        '{mk(5'b01101,5'd0,5'd0,5'd0,5'd0, lw(5'b01000,6'b0,1'b0,6'h1f)), 4'd0,1'b1, 7'h0,7'h0,7'h0,7'h0, 4'b0, 2'd0,3'd0,1'b0,3'd0, 4'd12},
        // R1 wrong prefix opcode
        '{mk(5'b00000,5'd0,5'd0,5'd0,5'd0, lw(5'b0,6'b0,1'b0,6'h1e)), 4'd0,1'b1, 7'h0,7'h0,7'h0,7'h0, 4'b0, 2'd0,3'd0,1'b0,3'd0, 4'd1},
        // R1 bit 6 set
        '{mk(5'b00000,5'd0,5'd0,5'd0,5'd0, lw(5'b0,6'b0,1'b1,6'h1f)), 4'd0,1'b1, 7'h0,7'h0,7'h0,7'h0, 4'b0, 2'd0,3'd0,1'b0,3'd0, 4'd1}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [47:0] w);
        @(negedge clk);
        insn = w;
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R1 idle word after reset has no prefix header
        apply(48'h0);
        chk("R1 reset idle illegal", 64'(illegal), 64'd1);

        for (int i = 0; i < NT; i++) begin
            apply(TV[i].insn);
            chk($sformatf("R%0d vec%0d illegal", TV[i].req, i), 64'(illegal), 64'(TV[i].ill));
            if (!TV[i].ill) begin
                chk($sformatf("R%0d vec%0d fmt", TV[i].req, i), 64'(fmt), 64'(TV[i].fmt));
                chk($sformatf("R%0d vec%0d nums", TV[i].req, i),
                    64'({rd_num, rs1_num, rs2_num, rs3_num}),
                    64'({TV[i].rd, TV[i].rs1, TV[i].rs2, TV[i].rs3}));
                chk($sformatf("R%0d vec%0d flags", TV[i].req, i),
                    64'({rd_vec, rs1_vec, rs2_vec, rs3_vec}), 64'(TV[i].vec));
                chk($sformatf("R%0d vec%0d type", TV[i].req, i),
                    64'({itype, pred, pred_twin, svlen}),
                    64'({TV[i].ity, TV[i].prd, TV[i].twin, TV[i].svl}));
            end
        end

        // R5 and R6: sweep the 6-bit rd field on a load in both modes
        for (int f = 0; f < 64; f++) begin
            for (int v = 0; v < 2; v++) begin
                logic [5:0] fld;
                logic [6:0] want;
                fld  = 6'(f);
                want = v[0] ? {fld[0], fld[5:1], 1'b0} : {1'b0, fld};
                apply(mk(5'b00000, 5'd0, fld[4:0], 5'd0, 5'd0,
                         lw({fld[5], 2'b00, v[0], 1'b0}, 6'b0, 1'b0, 6'h1f)));
                chk(v[0] ? "R6 vector rd sweep" : "R5 scalar rd sweep", 64'(rd_num), 64'(want));
            end
        end

        // R7: flag inference on R and FR4 formats
        for (int c = 0; c < 4; c++) begin
            apply(mk(5'b01100, 5'd0, 5'd1, 5'd1, 5'd1,
                     lw({3'b000, c[1], c[0]}, 6'b0, 1'b0, 6'h1f)));
            chk("R7 R-format rd inferred", 64'(rd_vec), 64'(c[1] | c[0]));
            apply(mk(5'b10011, 5'd1, 5'd1, 5'd1, 5'd1,
                     lw({3'b000, c[1], 1'b0}, {c[0], 5'b0}, 1'b0, 6'h1f)));
            chk("R7 FR4 rd/rs1 inferred", 64'({rd_vec, rs1_vec}), 64'({2{c[1] | c[0]}}));
        end

        // R11: every svlen code on an I-format op
        for (int s = 0; s < 4; s++) begin
            apply(mk(5'b00110, 5'd0, 5'd0, 5'd0, 5'd0,
                     lw(5'b0, {4'b0000, 2'(s)}, 1'b0, 6'h1f)));
            chk("R11 svlen code", 64'(svlen), (s == 0) ? 64'd4 : 64'(s));
        end

        // R4: other fp-unary function codes go to FI
        apply(mk(5'b10100, 5'b11110, 5'd0, 5'd0, 5'd0, lw(5'b0, 6'b0, 1'b0, 6'h1f)));
        chk("R4 fp move to FI", 64'(fmt), 64'd7);
        apply(mk(5'b10100, 5'b00100, 5'd0, 5'd0, 5'd0, lw(5'b0, 6'b0, 1'b0, 6'h1f)));
        chk("R4 fp sign-inject to FR", 64'(fmt), 64'd6);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule